// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block sits behind a two-byte I/O window in a multi-function peripheral chip. One address selects the index port and the other selects the data port. Software reaches a configuration register in two steps: it writes the register number to the index port, then reads or writes the data port. The configuration space stays closed until a key byte has been written to the index port twice in a row. A second key byte closes it again.

While the space is open, the block serves the chip-wide registers itself. These are the logical-device selector, the device identity, the revision and the vendor identity. Any register number of 0x30 or higher belongs to the logical device that is currently selected. For those numbers the block passes the access to an external register bus, carrying the device number, the register number and the data. The address decode that produces the two strobes and the select bit is done outside this block, and so are the logical devices themselves. Device number 0x06 is, by convention, the GPIO function.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset the space is locked, the index holds 0x00 and the logical-device selector holds 0x00.
- R2: The space opens after two back-to-back index-port writes of 0x87 (io_addr=0 selects the index port, io_addr=1 the data port).
- R3: Any index-port write other than 0x87, made while locked, clears a half-entered key. A later single 0x87 then leaves the space locked.
- R4: An index-port write of 0xAA while open locks the space, and that write does not change the index.
- R5: While locked, reads of either port return 0xFF. Data-port writes change no register and raise no forwarding strobe.
- R6: While open, an index-port write of any value other than 0xAA (0x87 included) stores that value as the index, and an index-port read returns it.
- R7: Register 0x07 is the logical-device selector. It can be read and written through the data port.
- R8: Registers 0x20 and 0x21 return the device ID high and low bytes, 0x22 returns the revision, and 0x23 and 0x24 return the vendor ID 0x1934 high and low bytes. Writes to these registers are ignored.
- R9: For an index of 0x30 or higher while open, a data-port write pulses ld_wr in that same cycle, with ld_num, ld_index and ld_wdata valid. A data-port read pulses ld_rd and returns ld_rdata in that same cycle.
- R10: Any other index below 0x30 reads as 0x00, ignores writes and raises no forwarding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Byte write strobe, one cycle per access |
| io_rd | input | 1 | Byte read strobe, one cycle per access |
| io_addr | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid in the cycle of io_rd |
| ld_wr | output | 1 | Forwarded write strobe to the logical-device bus |
| ld_rd | output | 1 | Forwarded read strobe to the logical-device bus |
| ld_num | output | 8 | Selected logical-device number |
| ld_index | output | 8 | Register number within the logical device |
| ld_wdata | output | 8 | Forwarded write byte |
| ld_rdata | input | 8 | Read byte returned by the logical-device bus |

## Verification
A wrong lock state shows up on the very next data read. A stuck-locked design returns 0xFF where a register value was expected, and a stuck-open design returns a register value where 0xFF was expected. A bad key counter shows up as a lock state that differs from the model after the second or third index write. A corrupted index or selector register shows up on the next data read or on the next forwarded strobe, where ld_index, ld_num or the strobe itself disagrees with the model. The bench replays a reference model every cycle, so any such divergence is caught within one access.

// File: rtl/cfg_port_pkg.sv
// Shared constants for the keyed configuration port.
// Assumes 8-bit registers and a single-bit port select.
package cfg_port_pkg;
    localparam int DW = 8;
    localparam logic [DW-1:0] KEY_OPEN  = 8'h87;
    localparam logic [DW-1:0] KEY_CLOSE = 8'hAA;
    localparam logic [DW-1:0] IDX_LDSEL = 8'h07;
    localparam logic [DW-1:0] IDX_DEVHI = 8'h20;
    localparam logic [DW-1:0] IDX_DEVLO = 8'h21;
    localparam logic [DW-1:0] IDX_REV   = 8'h22;
    localparam logic [DW-1:0] IDX_VENHI = 8'h23;
    localparam logic [DW-1:0] IDX_VENLO = 8'h24;
    localparam logic [DW-1:0] IDX_FWD   = 8'h30;
    localparam logic [DW-1:0] LOCKED_RD = 8'hFF;

    typedef enum logic {PORT_INDEX = 1'b0, PORT_DATA = 1'b1} port_sel_e;
endpackage

// File: rtl/cfg_key_unit.sv
// Lock/unlock tracker. It watches index-port writes for the double
// open key and the single close key.
// Assumes idx_wr is a one-cycle strobe qualified by the port select.
module cfg_key_unit
    import cfg_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          unlocked
);
    logic armed;

    // Key sequencer: arm on the first open key, open on the second,
    // disarm on any other byte, close on the close key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            armed    <= 1'b0;
        end else if (idx_wr) begin
            if (!unlocked) begin
                if (wdata == KEY_OPEN) begin
                    unlocked <= armed;
                    armed    <= ~armed;
                end else begin
                    armed <= 1'b0;
                end
            end else if (wdata == KEY_CLOSE) begin
                unlocked <= 1'b0;
                armed    <= 1'b0;
            end
        end
    end

    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_OPEN));

    // R4
    close_key_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && unlocked && wdata == KEY_CLOSE) |=> !unlocked);
endmodule

// File: rtl/cfg_regs.sv
// Index and logical-device selector registers.
// Assumes the strobes are already split by port select.
module cfg_regs
    import cfg_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unlocked,
    input  logic          idx_wr,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] index_q,
    output logic [DW-1:0] ldn_q
);
    // Index register: loaded by open-space index writes except the close key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (idx_wr && unlocked && wdata != KEY_CLOSE)
            index_q <= wdata;
    end

    // Selector register: loaded by open-space data writes to its index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ldn_q <= '0;
        else if (dat_wr && unlocked && index_q == IDX_LDSEL)
            ldn_q <= wdata;
    end

    // R5
    locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !unlocked) |=> ($stable(ldn_q) && $stable(index_q)));

    // R7
    ldsel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && unlocked && index_q == IDX_LDSEL) |=> ldn_q == $past(wdata));
endmodule

// File: rtl/cfg_access.sv
// Read-data selection and forwarding to the logical-device bus.
// Purely combinational. Assumes the identity values are fixed by parameters.
module cfg_access
    import cfg_port_pkg::*;
#(
    parameter logic [15:0]   DEV_ID  = 16'h0C2A,
    parameter logic [DW-1:0] DEV_REV = 8'h03,
    parameter logic [15:0]   VEN_ID  = 16'h1934
) (
    input  logic          unlocked,
    input  logic          idx_rd,
    input  logic          dat_rd,
    input  logic          dat_wr,
    input  logic [DW-1:0] index_q,
    input  logic [DW-1:0] ldn_q,
    input  logic [DW-1:0] fwd_rdata,
    output logic [DW-1:0] rdata,
    output logic          fwd_wr,
    output logic          fwd_rd
);
    logic in_fwd;
    logic [DW-1:0] local_rd;

    assign in_fwd = unlocked && (index_q >= IDX_FWD);
    assign fwd_wr = dat_wr && in_fwd;
    assign fwd_rd = dat_rd && in_fwd;

    // Local register file read decode.
    always_comb begin
        case (index_q)
            IDX_LDSEL: local_rd = ldn_q;
            IDX_DEVHI: local_rd = DEV_ID[15:8];
            IDX_DEVLO: local_rd = DEV_ID[7:0];
            IDX_REV:   local_rd = DEV_REV;
            IDX_VENHI: local_rd = VEN_ID[15:8];
            IDX_VENLO: local_rd = VEN_ID[7:0];
            default:   local_rd = '0;
        endcase
    end

    // Port read mux: locked pattern, index echo, forwarded or local data.
    always_comb begin
        if (!unlocked)
            rdata = LOCKED_RD;
        else if (idx_rd)
            rdata = index_q;
        else if (in_fwd)
            rdata = fwd_rdata;
        else
            rdata = local_rd;
    end
endmodule

// File: rtl/cfg_port_ctrl.sv
// Keyed two-byte configuration port: index at io_addr=0, data at io_addr=1.
// Assumes io_wr and io_rd are single-cycle strobes that never overlap.
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter logic [15:0]  DEV_ID  = 16'h0C2A,
    parameter logic [7:0]   DEV_REV = 8'h03,
    parameter logic [15:0]  VEN_ID  = 16'h1934
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic       io_addr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       ld_wr,
    output logic       ld_rd,
    output logic [7:0] ld_num,
    output logic [7:0] ld_index,
    output logic [7:0] ld_wdata,
    input  logic [7:0] ld_rdata
);
    logic idx_wr, idx_rd, dat_wr, dat_rd, unlocked;
    logic [DW-1:0] index_q, ldn_q;

    assign idx_wr = io_wr && (io_addr == PORT_INDEX);
    assign idx_rd = io_rd && (io_addr == PORT_INDEX);
    assign dat_wr = io_wr && (io_addr == PORT_DATA);
    assign dat_rd = io_rd && (io_addr == PORT_DATA);

    cfg_key_unit u_key (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
        .unlocked(unlocked)
    );

    cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .idx_wr(idx_wr),
        .dat_wr(dat_wr), .wdata(io_wdata), .index_q(index_q), .ldn_q(ldn_q)
    );

    cfg_access #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .VEN_ID(VEN_ID)) u_acc (
        .unlocked(unlocked), .idx_rd(idx_rd), .dat_rd(dat_rd), .dat_wr(dat_wr),
        .index_q(index_q), .ldn_q(ldn_q), .fwd_rdata(ld_rdata),
        .rdata(io_rdata), .fwd_wr(ld_wr), .fwd_rd(ld_rd)
    );

    assign ld_num   = ldn_q;
    assign ld_index = index_q;
    assign ld_wdata = io_wdata;

    // R5
    locked_read_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !unlocked) |-> io_rdata == LOCKED_RD);

    // R9
    fwd_needs_high_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr || ld_rd) |-> (ld_index >= IDX_FWD && (io_wr || io_rd) && io_addr));
endmodule

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb_top;
    localparam logic [15:0] T_DEV = 16'h0C2A;
    localparam logic [7:0]  T_REV = 8'h03;
    localparam logic [15:0] T_VEN = 16'h1934;

    logic clk = 0, rst_n = 0;
    logic io_wr = 0, io_rd = 0, io_addr = 0;
    logic [7:0] io_wdata = 0, io_rdata, ld_num, ld_index, ld_wdata, ld_rdata;
    logic ld_wr, ld_rd;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // Reference model state
    bit m_open = 0, m_armed = 0;
    int m_idx = 0, m_ldn = 0;

    always #4 clk = ~clk;

    // External logical-device bus stand-in
    assign ld_rdata = ld_index ^ ld_num ^ 8'h5A;

    cfg_port_ctrl #(.DEV_ID(T_DEV), .DEV_REV(T_REV), .VEN_ID(T_VEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ld_wr(ld_wr), .ld_rd(ld_rd),
        .ld_num(ld_num), .ld_index(ld_index), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_read(bit port);
        if (!m_open) return 8'hFF;
        if (!port) return m_idx;
        if (m_idx >= 8'h30) return (m_idx ^ m_ldn ^ 8'h5A) & 8'hFF;
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return 8'h0C;
            8'h21: return 8'h2A;
            8'h22: return 8'h03;
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            default: return 0;
        endcase
    endfunction

    // One bus cycle: drive at negedge, compare, then advance the model.
    task automatic acc(bit wr, bit port, int data, string req);
        bit fwd;
        @(negedge clk);
        io_wr = wr; io_rd = !wr; io_addr = port; io_wdata = data[7:0];
        #1;
        fwd = m_open && port && (m_idx >= 8'h30);
        if (!wr) chk(req, io_rdata, model_read(port));
        chk(req, ld_wr, wr && fwd);
        chk(req, ld_rd, !wr && fwd);
        if (wr && fwd) begin
            chk(req, ld_num, m_ldn);
            chk(req, ld_index, m_idx);
            chk(req, ld_wdata, data);
        end
        if (wr && !port) begin
            if (!m_open) begin
                if (data == 8'h87) begin
                    if (m_armed) begin m_open = 1; m_armed = 0; end
                    else m_armed = 1;
                end else m_armed = 0;
            end else if (data == 8'hAA) m_open = 0;
            else m_idx = data;
        end else if (wr && port && m_open && m_idx == 8'h07) m_ldn = data;
        @(negedge clk);
        io_wr = 0; io_rd = 0;
    endtask

    // Idle cycles are also compared: no forwarding strobe may appear.
    task automatic idle_chk(string req);
        @(negedge clk); #1;
        chk(req, ld_wr, 0);
        chk(req, ld_rd, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_chk("R1");
        rst_n = 1;
        acc(0, 1, 0, "R1");           // locked data read -> FF
        acc(0, 0, 0, "R5");           // locked index read -> FF
        acc(1, 0, 8'h87, "R3");
        acc(1, 0, 8'h05, "R3");
        acc(1, 0, 8'h87, "R3");
        acc(0, 1, 0, "R3");           // still locked
        acc(1, 1, 8'h33, "R5");       // locked data write ignored
        acc(1, 0, 8'h87, "R2");       // second consecutive key opens
        acc(0, 0, 0, "R1");           // index reset value 0
        acc(0, 1, 0, "R10");
        acc(1, 0, 8'h07, "R6");
        acc(0, 0, 0, "R6");
        acc(0, 1, 0, "R1");           // selector reset 0
        acc(1, 1, 8'h06, "R7");
        acc(0, 1, 0, "R7");
        for (int i = 8'h20; i <= 8'h24; i++) begin
            acc(1, 0, i, "R8");
            acc(0, 1, 0, "R8");
        end
        acc(1, 0, 8'h20, "R8");
        acc(1, 1, 8'hFF, "R8");
        acc(0, 1, 0, "R8");
        acc(1, 0, 8'h10, "R10");
        acc(1, 1, 8'h55, "R10");
        acc(0, 1, 0, "R10");
        acc(1, 0, 8'h2F, "R10");
        acc(1, 1, 8'h11, "R10");
        acc(1, 0, 8'h30, "R9");
        acc(1, 1, 8'hC3, "R9");
        acc(0, 1, 0, "R9");
        acc(1, 0, 8'hFF, "R9");
        acc(1, 1, 8'h3C, "R9");
        acc(0, 1, 0, "R9");
        acc(1, 0, 8'h07, "R7");
        acc(1, 1, 8'h02, "R7");
        acc(1, 0, 8'h40, "R9");
        acc(1, 1, 8'h99, "R9");
        acc(0, 1, 0, "R9");
        acc(1, 0, 8'h87, "R6");
        acc(0, 0, 0, "R6");
        acc(0, 1, 0, "R6");
        acc(1, 0, 8'h45, "R4");
        acc(1, 0, 8'hAA, "R4");
        acc(0, 1, 0, "R4");
        acc(0, 0, 0, "R5");
        acc(1, 1, 8'h77, "R5");
        acc(0, 1, 0, "R5");
        idle_chk("R5");
        acc(1, 0, 8'h87, "R2");
        acc(1, 0, 8'h87, "R2");
        acc(0, 0, 0, "R4");           // index kept at 0x45
        acc(1, 0, 8'h07, "R5");
        acc(0, 1, 0, "R5");           // selector still 0x02
        acc(1, 0, 8'h22, "R8");
        acc(0, 1, 0, "R8");
        idle_chk("R9");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule